// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sits in front of a translation lookaside buffer. It takes a 64-bit virtual address and a handful of processor status bits, and it decides how the access is resolved. An access can be mapped directly to a physical address, sent on to the TLB search, or rejected as an address error. For direct mappings the block also forms the physical address.

The block also reports two values that later exception logic needs: the effective privilege ring of the access and whether that ring runs with 64-bit addressing. The decision logic is combinational. One register stage holds all outputs, so every result appears one clock after its inputs.

The reset input is asserted asynchronously and is released through an internal synchronizer.

Top module: `seg_decoder`

## Requirements
- R1: The effective ring is the 2-bit ring field (00 kernel, 01 supervisor, 10 user). It is forced to 00 whenever the exception-level or error-level flag is set. The value 11 is passed through unchanged and counts as non-kernel.
- R2: The 64-bit flag equals the kernel-wide bit for ring 00 and the supervisor-wide bit for ring 01. For any other effective ring it equals the user-wide bit.
- R3: When address bits 63:62 are 10, the access is direct in every ring. The physical address is then address bits 43:0.
- R4: An address in the range 0 to 0x7FFFFFFF is classed as TLB in every ring.
- R5: An address whose bits 63:32 are zero and whose bit 31 is set is treated as if bits 63:32 were all ones. For example, 0x80000000 decodes exactly like 0xFFFFFFFF80000000.
- R6: In ring 00, a sign-extended address from 0xFFFFFFFF80000000 to 0xFFFFFFFFBFFFFFFF is direct. Its physical address is the low 29 address bits, with all higher bits zero.
- R7: In ring 00, any other address above 0x7FFFFFFF that is not covered by R3 is classed as TLB. In any other ring such an address is classed as error.
- R8: The class output is encoded as 00 direct, 01 TLB and 10 error. The value 11 never appears.
- R9: The physical address output is zero whenever the class is not direct.
- R10: While reset is active, the outputs hold class 10, address 0, ring 00 and flag 0. After reset, each output reflects the inputs that were present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| vaddr_i | input | 64 | Virtual address |
| ring_i | input | 2 | Current privilege ring field |
| exc_lvl_i | input | 1 | Exception-level flag; forces kernel ring |
| err_lvl_i | input | 1 | Error-level flag; forces kernel ring |
| wide_user_i | input | 1 | 64-bit addressing enable for user ring |
| wide_super_i | input | 1 | 64-bit addressing enable for supervisor ring |
| wide_kern_i | input | 1 | 64-bit addressing enable for kernel ring |
| cls_o | output | 2 | Access class: 00 direct, 01 TLB, 10 error |
| paddr_o | output | PA_W (44) | Physical address for direct accesses, else zero |
| ring_o | output | 2 | Effective privilege ring |
| wide_o | output | 1 | 64-bit addressing flag of the effective ring |

## Verification
Every output, whether class, physical address, ring or 64-bit flag, is due exactly one rising edge after its inputs are applied. The bench drives each stimulus on a falling edge, lets the next rising edge capture it, and compares all four outputs on the following falling edge. Consecutive stimuli therefore occupy consecutive cycles, and back-to-back changes are checked.

The sweep pairs every combination of the seven status bits with a list of addresses at each segment boundary. The reset values are sampled while reset is held.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;

  localparam int unsigned VA_W = 64;

  typedef enum logic [1:0] {
    CLS_DIRECT = 2'b00,
    CLS_TLB    = 2'b01,
    CLS_ERROR  = 2'b10
  } seg_class_e;

  typedef enum logic [1:0] {
    RING_KERNEL = 2'b00,
    RING_SUPER  = 2'b01,
    RING_USER   = 2'b10,
    RING_RSVD   = 2'b11
  } ring_e;

  typedef struct packed {
    ring_e ring;
    logic  wide;
  } mode_t;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/seg_priv_derive.sv
module seg_priv_derive
  import seg_dec_pkg::*;
(
  input  logic [1:0] ring_field_i,
  input  logic       exc_lvl_i,
  input  logic       err_lvl_i,
  input  logic       wide_user_i,
  input  logic       wide_super_i,
  input  logic       wide_kern_i,
  output mode_t      mode_o
);

  ring_e eff_ring;
  logic  eff_wide;

  always_comb begin
    eff_ring = ring_e'(ring_field_i);
    if (exc_lvl_i || err_lvl_i) eff_ring = RING_KERNEL;
    unique case (eff_ring)
      RING_KERNEL: eff_wide = wide_kern_i;
      RING_SUPER:  eff_wide = wide_super_i;
      default:     eff_wide = wide_user_i;
    endcase
  end

  assign mode_o = '{ring: eff_ring, wide: eff_wide};

endmodule

// File: rtl/seg_range_classify.sv
module seg_range_classify
  import seg_dec_pkg::*;
#(
  parameter int unsigned PA_W       = 44,
  parameter int unsigned PHYS_WIN_W = 44,
  parameter int unsigned KSEG_W     = 29
) (
  input  logic [VA_W-1:0] vaddr_i,
  input  ring_e           ring_i,
  output seg_class_e      cls_o,
  output logic [PA_W-1:0] paddr_o
);

  localparam int unsigned HALF_W = VA_W / 2;
  localparam int unsigned KWIN_W = VA_W - 30;

  logic [VA_W-1:0] ext_addr;
  logic            in_phys_win;
  logic            in_low_user;
  logic            in_kern_win;
  logic            is_kernel;

  always_comb begin
    ext_addr = vaddr_i;
    if (vaddr_i[VA_W-1:HALF_W] == '0 && vaddr_i[HALF_W-1])
      ext_addr[VA_W-1:HALF_W] = '1;
  end

  assign in_phys_win = (vaddr_i[VA_W-1:VA_W-2] == 2'b10);
  assign in_low_user = (vaddr_i[VA_W-1:31] == '0);
  assign in_kern_win = (ext_addr[VA_W-1:30] == {{(KWIN_W-2){1'b1}}, 2'b10});
  assign is_kernel   = (ring_i == RING_KERNEL);

  always_comb begin
    cls_o   = CLS_ERROR;
    paddr_o = '0;
    if (in_phys_win) begin
      cls_o                     = CLS_DIRECT;
      paddr_o[PHYS_WIN_W-1:0]   = vaddr_i[PHYS_WIN_W-1:0];
    end else if (in_low_user) begin
      cls_o = CLS_TLB;
    end else if (is_kernel && in_kern_win) begin
      cls_o                 = CLS_DIRECT;
      paddr_o[KSEG_W-1:0]   = ext_addr[KSEG_W-1:0];
    end else if (is_kernel) begin
      cls_o = CLS_TLB;
    end else begin
      cls_o = CLS_ERROR;
    end
  end

endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import seg_dec_pkg::*;
#(
  parameter int unsigned PA_W       = 44,
  parameter int unsigned PHYS_WIN_W = 44,
  parameter int unsigned KSEG_W     = 29,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [63:0]     vaddr_i,
  input  logic [1:0]      ring_i,
  input  logic            exc_lvl_i,
  input  logic            err_lvl_i,
  input  logic            wide_user_i,
  input  logic            wide_super_i,
  input  logic            wide_kern_i,
  output logic [1:0]      cls_o,
  output logic [PA_W-1:0] paddr_o,
  output logic [1:0]      ring_o,
  output logic            wide_o
);

  logic            rst_sync_n;
  mode_t           mode_d;
  seg_class_e      cls_d;
  logic [PA_W-1:0] paddr_d;

  seg_class_e      cls_q;
  logic [PA_W-1:0] paddr_q;
  mode_t           mode_q;

  seg_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  seg_priv_derive i_priv (
    .ring_field_i (ring_i),
    .exc_lvl_i    (exc_lvl_i),
    .err_lvl_i    (err_lvl_i),
    .wide_user_i  (wide_user_i),
    .wide_super_i (wide_super_i),
    .wide_kern_i  (wide_kern_i),
    .mode_o       (mode_d)
  );

  seg_range_classify #(
    .PA_W       (PA_W),
    .PHYS_WIN_W (PHYS_WIN_W),
    .KSEG_W     (KSEG_W)
  ) i_classify (
    .vaddr_i (vaddr_i),
    .ring_i  (mode_d.ring),
    .cls_o   (cls_d),
    .paddr_o (paddr_d)
  );

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cls_q   <= CLS_ERROR;
      paddr_q <= '0;
      mode_q  <= '{ring: RING_KERNEL, wide: 1'b0};
    end else begin
      cls_q   <= cls_d;
      paddr_q <= paddr_d;
      mode_q  <= mode_d;
    end
  end

  assign cls_o   = cls_q;
  assign paddr_o = paddr_q;
  assign ring_o  = mode_q.ring;
  assign wide_o  = mode_q.wide;

  AST_LEVEL_FORCES_KERNEL: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $past(rst_sync_n) && $past(exc_lvl_i || err_lvl_i) |-> ring_o == 2'b00); // R1
  AST_PHYS_WIN_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $past(rst_sync_n) && $past(vaddr_i[63:62] == 2'b10)
      |-> cls_o == 2'b00 && paddr_o[PHYS_WIN_W-1:0] == $past(vaddr_i[PHYS_WIN_W-1:0])); // R3
  AST_LOW_RANGE_TLB: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $past(rst_sync_n) && $past(vaddr_i <= 64'h7FFF_FFFF) |-> cls_o == 2'b01); // R4
  AST_KSEG_PA_NARROW: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $past(rst_sync_n) && cls_o == 2'b00 && $past(vaddr_i[63:62] != 2'b10)
      |-> (paddr_o >> KSEG_W) == '0); // R6
  AST_ERROR_NOT_KERNEL: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $past(rst_sync_n) && cls_o == 2'b10 |-> ring_o != 2'b00); // R7
  AST_CLASS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    cls_o != 2'b11); // R8
  AST_PA_ZERO_OFF_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    cls_o != 2'b00 |-> paddr_o == '0); // R9

endmodule

// File: tb/test_seg_decoder.sv
module test_seg_decoder;

  localparam int unsigned PA_W = 44;
  localparam int unsigned NADDR = 18;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic [63:0]     vaddr_i;
  logic [1:0]      ring_i;
  logic            exc_lvl_i, err_lvl_i, wide_user_i, wide_super_i, wide_kern_i;
  logic [1:0]      cls_o;
  logic [PA_W-1:0] paddr_o;
  logic [1:0]      ring_o;
  logic            wide_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic done   = 1'b0;

  always #2 clk_i = ~clk_i;

  seg_decoder i_seg_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .vaddr_i(vaddr_i), .ring_i(ring_i),
    .exc_lvl_i(exc_lvl_i), .err_lvl_i(err_lvl_i), .wide_user_i(wide_user_i),
    .wide_super_i(wide_super_i), .wide_kern_i(wide_kern_i),
    .cls_o(cls_o), .paddr_o(paddr_o), .ring_o(ring_o), .wide_o(wide_o)
  );

  function automatic logic [63:0] addr_at(int k);
    case (k)
      0:  return 64'h0;
      1:  return 64'h7FFF_FFFF;
      2:  return 64'h8000_0000;
      3:  return 64'h9FFF_FFFF;
      4:  return 64'hBFFF_FFFF;
      5:  return 64'hC000_0000;
      6:  return 64'hFFFF_FFFF;
      7:  return 64'h1_8000_0000;
      8:  return 64'hFFFF_FFFF_7FFF_FFFF;
      9:  return 64'hFFFF_FFFF_8000_0000;
      10: return 64'hFFFF_FFFF_BFFF_FFFF;
      11: return 64'hFFFF_FFFF_C000_0000;
      12: return 64'h8000_0000_0000_0000;
      13: return 64'hBFFF_FFFF_FFFF_FFFF;
      14: return 64'h9000_0000_1F60_0050;
      15: return 64'h4000_0000_0000_1000;
      16: return 64'hC000_0000_0000_0000;
      default: return 64'h7FFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_vector(input logic [63:0] a, input logic [6:0] st);
    logic [1:0]  e_ring;
    logic        e_wide;
    logic [1:0]  e_cls;
    logic [63:0] e_pa;
    logic [63:0] ext;
    string       tag;
    // drive on falling edge
    vaddr_i      = a;
    ring_i       = st[1:0];
    exc_lvl_i    = st[2];
    err_lvl_i    = st[3];
    wide_user_i  = st[4];
    wide_super_i = st[5];
    wide_kern_i  = st[6];
    // expectations from requirements
    e_ring = (st[2] || st[3]) ? 2'b00 : st[1:0];                         // R1
    e_wide = (e_ring == 2'b00) ? st[6] : (e_ring == 2'b01) ? st[5] : st[4]; // R2
    ext = ((a >> 32) == 0 && a[31]) ? (a | 64'hFFFF_FFFF_0000_0000) : a;    // R5
    e_pa = 64'h0;
    if ((a >> 62) == 64'd2) begin
      e_cls = 2'b00; e_pa = a % (64'd1 << 44); tag = "R3";
    end else if (a <= 64'h7FFF_FFFF) begin
      e_cls = 2'b01; tag = "R4";
    end else if (e_ring == 2'b00 && ext >= 64'hFFFF_FFFF_8000_0000 &&
                 ext <= 64'hFFFF_FFFF_BFFF_FFFF) begin
      e_cls = 2'b00; e_pa = ext % (64'd1 << 29);
      tag = (ext != a) ? "R5" : "R6";
    end else if (e_ring == 2'b00) begin
      e_cls = 2'b01; tag = "R7";
    end else begin
      e_cls = 2'b10; tag = "R7";
    end
    @(negedge clk_i);
    check(tag,   "class",       {62'd0, cls_o}, {62'd0, e_cls});
    check((e_cls == 2'b00) ? tag : "R9", "paddr", {20'd0, paddr_o}, e_pa);
    check("R1",  "ring",        {62'd0, ring_o}, {62'd0, e_ring});
    check("R2",  "wide",        {63'd0, wide_o}, {63'd0, e_wide});
    check("R8",  "class legal", {63'd0, cls_o == 2'b11}, 64'd0);
    check("R10", "latency",     {63'd0, cls_o === e_cls && ring_o === e_ring}, 64'd1);
  endtask

  initial begin
    rst_ni = 1'b0;
    vaddr_i = '0; ring_i = '0; exc_lvl_i = 0; err_lvl_i = 0;
    wide_user_i = 0; wide_super_i = 0; wide_kern_i = 0;
    repeat (3) @(negedge clk_i);
    // R10 reset values
    check("R10", "reset class", {62'd0, cls_o}, 64'd2);
    check("R10", "reset paddr", {20'd0, paddr_o}, 64'd0);
    check("R10", "reset ring",  {62'd0, ring_o}, 64'd0);
    check("R10", "reset wide",  {63'd0, wide_o}, 64'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    for (int k = 0; k < NADDR; k++) begin
      for (int s = 0; s < 128; s++) begin
        run_vector(addr_at(k), 7'(s));
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule